// File: doc/BRIEF.md
# Guarded Configuration Mode Controller

This unit sits in front of a bank of configuration registers that belong to a bus protocol engine. It keeps two guard bits: an initialization flag and a change-enable flag. It also keeps a two-bit operating-mode field. Writes to the guarded registers land only while both guard bits are set. At all other times those registers hold their contents, so the configuration cannot shift while the engine is on the bus.

The change-enable flag is accepted only if the initialization flag was already set before the write. Unlocking from running operation therefore takes two writes to the control register. A write that moves the mode field to a different legal value sets the initialization flag by itself. Clearing the initialization flag drops the change-enable flag in the same write and locks the bank again. The engine is allowed onto the bus only while the unit is out of initialization and the mode is normal.

Software reaches the unit through one write port and one combinational read port. The two ports use the same word address space.

Top module: `cfg_guard_ctrl`

## Requirements
- R1: A synchronous reset sets the initialization flag to 1, the change-enable flag to 0 and the mode to standby (01). It clears every guarded register to 0 and holds `bus_en` low.
- R2: A write to a guarded register takes effect only if both the initialization flag and the change-enable flag were 1 before the write. In any other state the register keeps its value.
- R3: The change-enable flag becomes 1 only if the initialization flag was already 1 before the write. A control write of 0b11 made while the initialization flag is 0 sets only the initialization flag.
- R4: A mode write with a legal value (01 standby, 10 normal) that differs from the current mode updates the mode and sets the initialization flag to 1. The change-enable flag keeps its value. Writing the current mode again changes nothing.
- R5: A mode write with a reserved value (00 or 11) changes neither the mode nor the guard flags.
- R6: `bus_en` is 1 exactly when the initialization flag is 0 and the mode is normal. It reflects a write from the cycle after that write.
- R7: A control write with the initialization bit 0 clears both flags in the same write. Guarded writes after it are ignored.
- R8: Address map: word 0 is the control register, with the initialization flag in bit 0 and the change-enable flag in bit 1. Word 1 holds the mode in bits [1:0]. Words 2 to 1+N_PROT are the guarded registers. Every other address reads 0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Combinational read data |
| bus_en | output | 1 | Bus participation enable for the protocol engine |

## Verification
Guarded writes are attempted in every guard state: locked after reset, fully unlocked, unlocked and then relocked by clearing the initialization flag, and initialization-only after a one-shot 0b11 write. These cases separate a controller that checks both flags from one that checks only one of them. Mode writes cover a legal change, a rewrite of the current value, and both reserved codes. This shows whether the automatic return to initialization fires only on a real change. The bus enable is watched as each of its two inputs toggles.

// File: rtl/cgc_pkg.sv
package cgc_pkg;

    localparam int CTRL_WORD = 0;
    localparam int MODE_WORD = 1;
    localparam int PROT_BASE = 2;

    typedef enum logic [1:0] {
        MODE_RSV_LO = 2'b00,
        MODE_STBY   = 2'b01,
        MODE_NORM   = 2'b10,
        MODE_RSV_HI = 2'b11
    } op_mode_e;

    typedef struct packed {
        logic chg_en;
        logic in_init;
    } guard_t;

    localparam guard_t GUARD_RESET = '{chg_en: 1'b0, in_init: 1'b1};

    function automatic logic mode_legal(input logic [1:0] m);
        return (m == MODE_STBY) || (m == MODE_NORM);
    endfunction

    // Next guard state for a control write. The change-enable flag needs
    // the init flag both before and after the write.
    function automatic guard_t guard_after_write(input guard_t cur,
                                                 input logic   want_init,
                                                 input logic   want_chg);
        guard_t nxt;
        nxt.in_init = want_init;
        nxt.chg_en  = want_init & want_chg & cur.in_init;
        return nxt;
    endfunction

endpackage

// File: rtl/cgc_decode.sv
module cgc_decode #(
    parameter int ADDR_W = 4,
    parameter int N_PROT = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              ctrl_sel,
    output logic              mode_sel,
    output logic [N_PROT-1:0] prot_sel
);
    import cgc_pkg::*;

    assign ctrl_sel = wr_en && (wr_addr == ADDR_W'(CTRL_WORD));
    assign mode_sel = wr_en && (wr_addr == ADDR_W'(MODE_WORD));

    for (genvar i = 0; i < N_PROT; i++) begin : g_sel
        assign prot_sel[i] = wr_en && (wr_addr == ADDR_W'(PROT_BASE + i));
    end

    always_comb begin
        assert ($countones({ctrl_sel, mode_sel, prot_sel}) <= 1)
            else $error("AST_ONE_TARGET"); // R8
    end
endmodule

// File: rtl/cgc_guard.sv
module cgc_guard (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctrl_sel,
    input  logic                mode_sel,
    input  logic [1:0]          wr_bits,
    output cgc_pkg::guard_t     grd,
    output cgc_pkg::op_mode_e   mode,
    output logic                unlock,
    output logic                bus_en
);
    import cgc_pkg::*;

    logic mode_change;
    assign mode_change = mode_sel && mode_legal(wr_bits) && (wr_bits != mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            grd  <= GUARD_RESET;
            mode <= MODE_STBY;
        end else if (ctrl_sel) begin
            grd <= guard_after_write(grd, wr_bits[0], wr_bits[1]);
        end else if (mode_change) begin
            mode        <= op_mode_e'(wr_bits);
            grd.in_init <= 1'b1;
        end
    end

    assign unlock = grd.in_init & grd.chg_en;
    assign bus_en = !grd.in_init && (mode == MODE_NORM);

    AST_CHG_NEEDS_INIT: assert property (@(posedge clk) disable iff (rst)
        grd.chg_en |-> grd.in_init); // R3
    AST_CHG_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        ctrl_sel && !grd.in_init |=> !grd.chg_en); // R3
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mode_legal(mode)); // R5
    AST_RSV_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        mode_sel && !mode_legal(wr_bits) |=> $stable(mode) && $stable(grd)); // R5
    AST_MODE_CHG_INIT: assert property (@(posedge clk) disable iff (rst)
        mode_sel && (wr_bits != mode) && mode_legal(wr_bits) |=> grd.in_init); // R4
    AST_CLR_INIT_CHG: assert property (@(posedge clk) disable iff (rst)
        ctrl_sel && !wr_bits[0] |=> !grd.chg_en && !grd.in_init); // R7
endmodule

// File: rtl/cgc_prot_bank.sv
module cgc_prot_bank #(
    parameter int DATA_W = 32,
    parameter int N_PROT = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_PROT-1:0]             prot_sel,
    input  logic                          unlock,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [N_PROT-1:0][DATA_W-1:0] q
);
    for (genvar i = 0; i < N_PROT; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= '0;
            else if (prot_sel[i] && unlock)
                q[i] <= wr_data;
        end

        AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
            prot_sel[i] && !unlock |=> $stable(q[i])); // R2
        AST_UNLOCKED_WRITE: assert property (@(posedge clk) disable iff (rst)
            prot_sel[i] && unlock |=> q[i] == $past(wr_data)); // R2
    end
endmodule

// File: rtl/cfg_guard_ctrl.sv
module cfg_guard_ctrl #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int N_PROT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_en
);
    import cgc_pkg::*;

    localparam int N_WORDS = PROT_BASE + N_PROT;

    initial begin
        assert (N_WORDS <= (1 << ADDR_W)) else $error("address space too small");
        assert (DATA_W >= 2) else $error("data too narrow");
    end

    logic                          ctrl_sel;
    logic                          mode_sel;
    logic [N_PROT-1:0]             prot_sel;
    guard_t                        grd;
    op_mode_e                      mode;
    logic                          unlock;
    logic [N_PROT-1:0][DATA_W-1:0] prot_q;

    cgc_decode #(.ADDR_W(ADDR_W), .N_PROT(N_PROT)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .ctrl_sel(ctrl_sel),
        .mode_sel(mode_sel),
        .prot_sel(prot_sel)
    );

    cgc_guard u_grd (
        .clk     (clk),
        .rst     (rst),
        .ctrl_sel(ctrl_sel),
        .mode_sel(mode_sel),
        .wr_bits (wr_data[1:0]),
        .grd     (grd),
        .mode    (mode),
        .unlock  (unlock),
        .bus_en  (bus_en)
    );

    cgc_prot_bank #(.DATA_W(DATA_W), .N_PROT(N_PROT)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .prot_sel(prot_sel),
        .unlock  (unlock),
        .wr_data (wr_data),
        .q       (prot_q)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(CTRL_WORD)) begin
            rd_data[1:0] = {grd.chg_en, grd.in_init};
        end else if (rd_addr == ADDR_W'(MODE_WORD)) begin
            rd_data[1:0] = mode;
        end else begin
            for (int i = 0; i < N_PROT; i++) begin
                if (rd_addr == ADDR_W'(PROT_BASE + i))
                    rd_data = prot_q[i];
            end
        end
    end

    AST_BUS_EN_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_en) |-> $past(ctrl_sel) && !$past(wr_data[0])); // R6
    AST_BUS_EN_MODE_DROP: assert property (@(posedge clk) disable iff (rst)
        bus_en && mode_sel && (wr_data[1:0] == MODE_STBY) |=> !bus_en); // R6
endmodule

// File: tb/sim_cfg_guard_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_guard_ctrl;

    localparam real HALF = 2.5;

    typedef struct packed {
        logic        we;
        logic [3:0]  wa;
        logic [31:0] wd;
        logic [3:0]  ra;
        logic [31:0] er;
        logic        eb;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd2, 32'h0000AAAA, 4'd2, 32'h0,        1'b0, 4'd2}, // R2 locked after reset
        '{1'b1, 4'd0, 32'h3,        4'd0, 32'h3,        1'b0, 4'd3}, // R3 init already set
        '{1'b1, 4'd2, 32'h00001234, 4'd2, 32'h00001234, 1'b0, 4'd2}, // R2 unlocked write
        '{1'b1, 4'd5, 32'hDEADBEEF, 4'd5, 32'hDEADBEEF, 1'b0, 4'd8}, // R8 last guarded word
        '{1'b1, 4'd0, 32'h0,        4'd0, 32'h0,        1'b0, 4'd7}, // R7 leave init
        '{1'b1, 4'd2, 32'h00005555, 4'd2, 32'h00001234, 1'b0, 4'd7}, // R7 relocked
        '{1'b1, 4'd0, 32'h3,        4'd0, 32'h1,        1'b0, 4'd3}, // R3 one-shot 11
        '{1'b1, 4'd3, 32'h00000077, 4'd3, 32'h0,        1'b0, 4'd2}, // R2 init only
        '{1'b1, 4'd1, 32'h2,        4'd1, 32'h2,        1'b0, 4'd4}, // R4 to normal
        '{1'b1, 4'd0, 32'h0,        4'd0, 32'h0,        1'b1, 4'd6}, // R6 on bus
        '{1'b1, 4'd1, 32'h3,        4'd1, 32'h2,        1'b1, 4'd5}, // R5 reserved 11
        '{1'b1, 4'd1, 32'h0,        4'd0, 32'h0,        1'b1, 4'd5}, // R5 reserved 00
        '{1'b1, 4'd1, 32'h2,        4'd0, 32'h0,        1'b1, 4'd4}, // R4 same mode
        '{1'b1, 4'd1, 32'h1,        4'd0, 32'h1,        1'b0, 4'd4}, // R4 forced init
        '{1'b1, 4'd0, 32'h1,        4'd0, 32'h1,        1'b0, 4'd3}, // R3 init only
        '{1'b1, 4'd0, 32'h3,        4'd0, 32'h3,        1'b0, 4'd3}, // R3 unlock
        '{1'b1, 4'd1, 32'h2,        4'd0, 32'h3,        1'b0, 4'd4}, // R4 keeps change-enable
        '{1'b1, 4'd0, 32'h0,        4'd1, 32'h2,        1'b1, 4'd6}, // R6 back on bus
        '{1'b0, 4'd0, 32'h0,        4'd15, 32'h0,       1'b1, 4'd8}  // R8 unmapped
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  rd_addr;
    logic [31:0] rd_data;
    logic        bus_en;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(HALF) clk = ~clk;

    cfg_guard_ctrl u0 (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .bus_en (bus_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        read_chk("R1", 4'd0, 32'h1);
        read_chk("R1", 4'd1, 32'h1);
        read_chk("R1", 4'd2, 32'h0);
        chk("R1", {31'b0, bus_en}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VECS[i].we; wr_addr = VECS[i].wa; wr_data = VECS[i].wd;
            rd_addr = VECS[i].ra;
            @(negedge clk);
            wr_en = 1'b0;
            #1;
            chk($sformatf("R%0d vec%0d rd", VECS[i].req, i), rd_data, VECS[i].er);
            chk($sformatf("R%0d vec%0d bus", VECS[i].req, i), {31'b0, bus_en}, {31'b0, VECS[i].eb});
        end

        // R1 reset in the middle of operation
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        read_chk("R1", 4'd0, 32'h1);
        read_chk("R1", 4'd1, 32'h1);
        read_chk("R1", 4'd2, 32'h0);
        read_chk("R1", 4'd5, 32'h0);
        chk("R1", {31'b0, bus_en}, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule